// File: doc/BRIEF.md
# Idle-Input Sleep Mode Detector

This block sits next to a windowed watchdog and notices when the host has stopped toggling the watchdog-clear line. It counts the timeout reset pulses the watchdog keeps producing while the host is silent. After three such pulses in a row with no clear activity, it puts the supervisor into a low-power sleep mode. In sleep it selects the slow timebase, blanks the watchdog's own reset pulses and produces a slow periodic reset pulse of its own. The merged active-low reset output carries that pulse.

The clear line is raw and asynchronous. It passes through a two-flop synchronizer before edge detection, so one edge of either polarity counts as exactly one activity event. Any such edge clears the missed-period count and, in sleep, wakes the block. An asynchronous power-on reset also returns the block to the awake state. The pulse width and period are parameters counted in slow-timebase ticks.

Top module: `idle_sleep_det`

## Requirements
- R1: Right after reset, sleep_o is 0, tb_sel_o is 0, tick_o follows fast_tick_i, slp_pulse_o is 0, and rst_no is 1 while wd_pulse_i is 0.
- R2: The block counts falling edges of wd_pulse_i while awake. The third one in a row with no clear edge in between sets sleep_o on the same clock edge that samples it. After only two such edges, sleep_o stays 0.
- R3: A clear edge sets the missed-period count back to zero. After it, three fresh falling edges of wd_pulse_i are needed to enter sleep.
- R4: A change of clr_raw_i, rising or falling, clears sleep_o on the third rising clock edge after the change, and not before. A single change wakes the block once and leaves the count at zero.
- R5: tb_sel_o is 1 exactly while asleep. tick_o equals slow_tick_i while asleep and fast_tick_i while awake.
- R6: While asleep, count the slow_tick_i ticks sampled since sleep was entered as k. slp_pulse_o is 1 exactly when k mod SLP_PERIOD is at least SLP_PERIOD-SLP_WIDTH. slp_pulse_o is always 0 while awake.
- R7: Awake, rst_no is the inverse of wd_pulse_i. Asleep, rst_no is the inverse of slp_pulse_o, and wd_pulse_i has no effect on it.
- R8: Driving rst_ni low while asleep returns sleep_o and tb_sel_o to 0 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| fast_tick_i | input | 1 | Tick enable from the normal timebase |
| slow_tick_i | input | 1 | Tick enable from the slow timebase |
| wd_pulse_i | input | 1 | Watchdog timeout reset pulse, high while active |
| clr_raw_i | input | 1 | Raw asynchronous watchdog-clear line |
| sleep_o | output | 1 | High while in sleep mode |
| tb_sel_o | output | 1 | Timebase select, 1 selects the slow source |
| tick_o | output | 1 | Tick of the selected timebase |
| slp_pulse_o | output | 1 | Sleep-mode periodic reset pulse, high active |
| rst_no | output | 1 | Merged reset, active low |

## Verification
The assertions assume that clr_raw_i holds each level for at least SYNC_STAGES clock cycles, so that every detected edge lasts one cycle. They also assume that wd_pulse_i stays high for at least one full cycle, so that each of its falling edges is seen once. The bench flips the clear line only at a falling clock edge and then leaves it alone for several cycles. It drives each watchdog pulse high for two whole cycles, and it drives slow ticks as single-cycle strobes separated by an idle cycle.

// File: rtl/isd_pkg.sv
package isd_pkg;
  typedef enum logic {
    MODE_AWAKE = 1'b0,
    MODE_SLEEP = 1'b1
  } mode_e;
endpackage

// File: rtl/isd_clr_sync.sv
module isd_clr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic edge_o
);
  // sh_q[STAGES-1] is the synchronized level, sh_q[STAGES] its delayed copy
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], raw_i};
  end

  assign edge_o = sh_q[STAGES] ^ sh_q[STAGES-1];

  // input held >= STAGES cycles: one-cycle edge strobe
  assert_edge_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> !edge_o);
endmodule

// File: rtl/isd_miss_cnt.sv
module isd_miss_cnt #(
  parameter int LIMIT = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wd_pulse_i,
  input  logic clr_edge_i,
  input  logic hold_i,
  output logic fall_o,
  output logic hit_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic          wd_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wd_q <= 1'b0;
    else         wd_q <= wd_pulse_i;
  end

  assign fall_o = wd_q & ~wd_pulse_i;
  assign hit_o  = fall_o && (cnt_q == LAST) && !hold_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_edge_i || hold_i) cnt_q <= '0;
    else if (fall_o)             cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assert_cnt_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(LIMIT));

  assert_clr_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_edge_i |=> (cnt_q == '0));
endmodule

// File: rtl/isd_pulse_gen.sv
module isd_pulse_gen #(
  parameter int PERIOD = 1100,
  parameter int WIDTH  = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic tick_i,
  output logic pulse_o
);
  localparam int PW = $clog2(PERIOD);
  localparam logic [PW-1:0] START = PW'(PERIOD - WIDTH);
  localparam logic [PW-1:0] TOP   = PW'(PERIOD - 1);

  logic [PW-1:0] phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       phase_q <= '0;
    else if (!active_i) phase_q <= '0;
    else if (tick_i)   phase_q <= (phase_q == TOP) ? '0 : phase_q + 1'b1;
  end

  // pulse sits at the tail of each period
  assign pulse_o = active_i && (phase_q >= START);

  assert_phase_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q <= TOP);

  assert_idle_phase_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> (phase_q == '0));
endmodule

// File: rtl/idle_sleep_det.sv
module idle_sleep_det #(
  parameter int MISS_LIMIT  = 3,
  parameter int SLP_PERIOD  = 1100,
  parameter int SLP_WIDTH   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fast_tick_i,
  input  logic slow_tick_i,
  input  logic wd_pulse_i,
  input  logic clr_raw_i,
  output logic sleep_o,
  output logic tb_sel_o,
  output logic tick_o,
  output logic slp_pulse_o,
  output logic rst_no
);
  import isd_pkg::*;

  mode_e mode_q;
  logic  asleep, clr_edge, wd_fall, miss_hit, slp_pulse;

  isd_clr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  (clr_raw_i),
    .edge_o (clr_edge)
  );

  isd_miss_cnt #(.LIMIT(MISS_LIMIT)) u_miss (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wd_pulse_i (wd_pulse_i),
    .clr_edge_i (clr_edge),
    .hold_i     (asleep),
    .fall_o     (wd_fall),
    .hit_o      (miss_hit)
  );

  isd_pulse_gen #(.PERIOD(SLP_PERIOD), .WIDTH(SLP_WIDTH)) u_pulse (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (asleep),
    .tick_i   (slow_tick_i),
    .pulse_o  (slp_pulse)
  );

  // clear activity wins over a same-cycle entry
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       mode_q <= MODE_AWAKE;
    else if (clr_edge) mode_q <= MODE_AWAKE;
    else if (miss_hit) mode_q <= MODE_SLEEP;
  end

  assign asleep      = (mode_q == MODE_SLEEP);
  assign sleep_o     = asleep;
  assign tb_sel_o    = asleep;
  assign tick_o      = asleep ? slow_tick_i : fast_tick_i;
  assign slp_pulse_o = slp_pulse;
  assign rst_no      = asleep ? ~slp_pulse : ~wd_pulse_i;

  assert_enter_on_fall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(asleep) |-> $past(wd_fall));

  assert_wake_on_edge_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (asleep && clr_edge) |=> !asleep);

  assert_wd_masked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (asleep && !slp_pulse) |-> rst_no);

  assert_awake_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !asleep |-> !slp_pulse_o);
endmodule

// File: tb/sim_idle_sleep_det.sv
module sim_idle_sleep_det;
  localparam int PER = 1100;
  localparam int WID = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fast_t = 1'b0, slow_t = 1'b0, wd = 1'b0, clr = 1'b0;
  logic sleep, tb_sel, tick, slp_pulse, rst_n_o;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  idle_sleep_det #(.SLP_PERIOD(PER), .SLP_WIDTH(WID)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .fast_tick_i(fast_t), .slow_tick_i(slow_t),
    .wd_pulse_i(wd), .clr_raw_i(clr), .sleep_o(sleep), .tb_sel_o(tb_sel),
    .tick_o(tick), .slp_pulse_o(slp_pulse), .rst_no(rst_n_o)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; wd = 1'b0; slow_t = 1'b0; fast_t = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic wd_pulse();
    @(negedge clk); wd = 1'b1;
    repeat (2) @(negedge clk); wd = 1'b0;
    @(negedge clk);
  endtask

  task automatic flip_clr();
    @(negedge clk); clr = ~clr;
    repeat (4) @(negedge clk);
  endtask

  task automatic go_sleep();
    wd_pulse(); wd_pulse(); wd_pulse();
  endtask

  task automatic t_reset_r1();
    do_reset();
    check("R1 sleep", sleep, 1'b0);
    check("R1 tb_sel", tb_sel, 1'b0);
    check("R1 pulse", slp_pulse, 1'b0);
    check("R1 rst_no", rst_n_o, 1'b1);
    fast_t = 1'b1; #1; check("R1 tick fast", tick, 1'b1); fast_t = 1'b0;
  endtask

  task automatic t_entry_r2();
    do_reset();
    wd_pulse(); wd_pulse();
    check("R2 two pulses", sleep, 1'b0);
    wd_pulse();
    check("R2 third pulse", sleep, 1'b1);
  endtask

  task automatic t_clear_r3();
    do_reset();
    wd_pulse(); wd_pulse();
    flip_clr();
    wd_pulse(); wd_pulse();
    check("R3 count restarted", sleep, 1'b0);
    wd_pulse();
    check("R3 third fresh", sleep, 1'b1);
  endtask

  task automatic wake_check(input string tag);
    @(negedge clk); clr = ~clr;
    repeat (2) @(posedge clk); @(negedge clk);
    check({tag, " held two edges"}, sleep, 1'b1);
    @(negedge clk);
    check({tag, " woke third edge"}, sleep, 1'b0);
  endtask

  task automatic t_wake_r4();
    do_reset(); clr = 1'b0;
    go_sleep();
    wake_check("R4 rising");
    repeat (3) @(negedge clk);
    wd_pulse(); wd_pulse();
    check("R4 single wake count zero", sleep, 1'b0);
    wd_pulse();
    check("R4 resleep", sleep, 1'b1);
    wake_check("R4 falling");
  endtask

  task automatic t_mux_r5();
    do_reset(); go_sleep();
    check("R5 tb_sel asleep", tb_sel, 1'b1);
    @(negedge clk); fast_t = 1'b1; slow_t = 1'b0; #1;
    check("R5 fast ignored asleep", tick, 1'b0);
    @(negedge clk); fast_t = 1'b0; slow_t = 1'b1; #1;
    check("R5 slow passed asleep", tick, 1'b1);
    slow_t = 1'b0;
  endtask

  task automatic t_pulse_r6_r7();
    int k;
    do_reset(); go_sleep();
    k = 0;
    @(negedge clk); wd = 1'b1; #1;
    check("R7 wd masked asleep", rst_n_o, 1'b1);
    @(negedge clk); wd = 1'b0;
    for (int i = 0; i < 2 * PER + 2; i++) begin
      @(negedge clk); slow_t = 1'b1;
      @(negedge clk); slow_t = 1'b0;
      k++;
      if ((k % PER) >= PER - 4 || (k % PER) <= 1) begin
        check("R6 pulse phase", slp_pulse, ((k % PER) >= PER - WID));
        check("R7 rst follows pulse", rst_n_o, !((k % PER) >= PER - WID));
      end
    end
    check("R8 asleep before power cycle", sleep, 1'b1);
    #2 rst_n = 1'b0; #1;
    check("R8 async exit", sleep, 1'b0);
    check("R8 tb_sel back", tb_sel, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
    wd = 1'b1; #1;
    check("R7 wd drives awake", rst_n_o, 1'b0);
    check("R6 no pulse awake", slp_pulse, 1'b0);
    @(negedge clk); wd = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset_r1();
    t_entry_r2();
    t_clear_r3();
    t_wake_r4();
    t_mux_r5();
    t_pulse_r6_r7();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule